// File: doc/BRIEF.md
# Fractional SPI Bit-Clock Generator

This block derives the serial clock of an SPI master from a fast reference clock. An 8-bit rate field sets the bit rate to the reference rate times the field over 512. The field is meant to hold a power of two from 1 to 256. Because the field has only eight bits, the all-ones value stands in for 256, and that value gives half the reference rate. Each chip select keeps its own rate field in the top byte of its parameter word, and the surrounding controller presents the field of the selected device on `rate_i`.

Inside the block, an accumulator adds the rate to a phase register on every reference cycle. Each carry out of the register ends one half-period of the serial clock, so the serial clock toggles on each carry. Each toggle comes with a one-cycle strobe. The strobe also says whether the edge is the one where data is sampled or the one where new data is launched, as set by the clock-phase input. While `run_i` is low, the phase clears and the clock rests at the idle polarity. A rate of zero produces no edges. Rates that are not a power of two give a defined result: over 256 active cycles, the number of edges equals the field value.

Top module: `bclk_gen`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `sclk_o` is 0 and `edge_o`, `sample_o` and `launch_o` are 0.
- R2: In the cycle after `run_i` is sampled low, `sclk_o` equals the `cpol_i` value sampled with it, no strobe is high, and the phase restarts from zero.
- R3: With `run_i` high and a power-of-two rate N (1 to 128), `sclk_o` toggles once every 256/N reference cycles. The first toggle comes 256/N cycles after `run_i` is first sampled high. A full clock period is therefore 512/N cycles.
- R4: Rate value 255 acts as 256: `sclk_o` toggles on every cycle while running.
- R5: Rate value 0 produces no edges, and `sclk_o` holds its level.
- R6: `edge_o` is high for exactly the cycles in which `sclk_o` has just changed while running, one cycle per change.
- R7: A leading edge is one where `sclk_o` leaves the `cpol_i` level. With `cpha_i`=0, leading edges raise `sample_o` and trailing edges raise `launch_o`. With `cpha_i`=1 this is reversed. The two are never high together, and their OR equals `edge_o`.
- R8: With any nonzero rate N below 255, exactly N edges occur in the first 256 cycles after `run_i` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| run_i | input | 1 | Enables edge generation; low parks the clock at idle |
| rate_i | input | FIELD_W | Rate field; bit rate = reference x rate / 512, all-ones acts as 256 |
| cpol_i | input | 1 | Idle level of the serial clock |
| cpha_i | input | 1 | Clock phase: selects which edge samples and which launches |
| sclk_o | output | 1 | Serial clock level |
| edge_o | output | 1 | One-cycle strobe for each serial clock edge |
| sample_o | output | 1 | Strobe for an edge on which data is sampled |
| launch_o | output | 1 | Strobe for an edge on which data is launched |

## Verification
The bench builds the block with the default 8-bit rate field. This keeps the slowest setting, where a half-period is 256 cycles, short enough to run through a full clock period and more. The all-ones substitution and the every-cycle toggle are covered too. At this width, a non-power-of-two rate can be checked for its exact edge count over a single 256-cycle window. All four polarity and phase combinations are driven, so both leading and trailing edges are seen as sample edges and as launch edges.

// File: rtl/bclk_pkg.sv
package bclk_pkg;
    localparam int RATE_W_DEF = 8;

    typedef struct packed {
        logic sclk;
        logic edge_s;
        logic sample;
        logic launch;
    } shaper_t;

    localparam shaper_t SHAPER_RST = '{sclk: 1'b0, edge_s: 1'b0, sample: 1'b0, launch: 1'b0};
endpackage

// File: rtl/bclk_phase_acc.sv
module bclk_phase_acc #(
    parameter int FIELD_W = bclk_pkg::RATE_W_DEF
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               run_i,
    input  logic [FIELD_W-1:0] rate_i,
    output logic               carry_o
);
    localparam int STEP_W = FIELD_W + 1;
    localparam int SUM_W  = FIELD_W + 2;
    localparam logic [FIELD_W-1:0] ALL_ONES  = '1;
    localparam logic [STEP_W-1:0]  FULL_STEP = {1'b1, {FIELD_W{1'b0}}};

    typedef struct packed {
        logic [FIELD_W-1:0] acc;
    } acc_t;

    acc_t              st_d, st_q;
    logic [STEP_W-1:0] step;
    logic [SUM_W-1:0]  sum;

    always_comb begin
        step    = (rate_i == ALL_ONES) ? FULL_STEP : {1'b0, rate_i};
        sum     = SUM_W'(st_q.acc) + SUM_W'(step);
        carry_o = run_i & (sum[SUM_W-1:FIELD_W] != '0);
        st_d    = st_q;
        if (run_i) begin
            st_d.acc = sum[FIELD_W-1:0];
        end else begin
            st_d.acc = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/bclk_edge_shaper.sv
module bclk_edge_shaper (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_i,
    input  logic cpol_i,
    input  logic cpha_i,
    input  logic carry_i,
    output logic sclk_o,
    output logic edge_o,
    output logic sample_o,
    output logic launch_o
);
    import bclk_pkg::*;

    shaper_t st_d, st_q;
    logic    next_lvl;
    logic    leading;

    always_comb begin
        next_lvl    = ~st_q.sclk;
        leading     = (next_lvl != cpol_i);
        st_d        = st_q;
        st_d.edge_s = 1'b0;
        st_d.sample = 1'b0;
        st_d.launch = 1'b0;
        if (!run_i) begin
            st_d.sclk = cpol_i;
        end else if (carry_i) begin
            st_d.sclk   = next_lvl;
            st_d.edge_s = 1'b1;
            st_d.sample = leading ^ cpha_i;
            st_d.launch = ~(leading ^ cpha_i);
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= SHAPER_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign sclk_o   = st_q.sclk;
    assign edge_o   = st_q.edge_s;
    assign sample_o = st_q.sample;
    assign launch_o = st_q.launch;
endmodule

// File: rtl/bclk_gen.sv
module bclk_gen #(
    parameter int FIELD_W = bclk_pkg::RATE_W_DEF
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               run_i,
    input  logic [FIELD_W-1:0] rate_i,
    input  logic               cpol_i,
    input  logic               cpha_i,
    output logic               sclk_o,
    output logic               edge_o,
    output logic               sample_o,
    output logic               launch_o
);
    logic carry;

    bclk_phase_acc #(.FIELD_W(FIELD_W)) u_acc (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .run_i   (run_i),
        .rate_i  (rate_i),
        .carry_o (carry)
    );

    bclk_edge_shaper u_shape (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .run_i    (run_i),
        .cpol_i   (cpol_i),
        .cpha_i   (cpha_i),
        .carry_i  (carry),
        .sclk_o   (sclk_o),
        .edge_o   (edge_o),
        .sample_o (sample_o),
        .launch_o (launch_o)
    );
endmodule

// File: rtl/bclk_gen_chk.sv
module bclk_gen_chk #(
    parameter int FIELD_W = 8
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic               run_i,
    input logic [FIELD_W-1:0] rate_i,
    input logic               cpol_i,
    input logic               sclk_o,
    input logic               edge_o,
    input logic               sample_o,
    input logic               launch_o
);
    localparam logic [FIELD_W-1:0] ALL_ONES = '1;

    assert_strobe_split_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(sample_o && launch_o) && ((sample_o || launch_o) == edge_o));

    assert_edge_toggles_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(rst_ni) && edge_o) |-> (sclk_o != $past(sclk_o)));

    assert_no_silent_toggle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(rst_ni) && (sclk_o != $past(sclk_o)) && !edge_o) |-> !$past(run_i));

    assert_idle_level_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(rst_ni) && !$past(run_i)) |-> ((sclk_o == $past(cpol_i)) && !edge_o));

    assert_zero_rate_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(rst_ni) && $past(run_i) && ($past(rate_i) == '0)) |-> !edge_o);

    assert_full_rate_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(rst_ni) && $past(run_i) && ($past(rate_i) == ALL_ONES)) |-> edge_o);
endmodule

bind bclk_gen bclk_gen_chk #(.FIELD_W(FIELD_W)) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run_i),
    .rate_i   (rate_i),
    .cpol_i   (cpol_i),
    .sclk_o   (sclk_o),
    .edge_o   (edge_o),
    .sample_o (sample_o),
    .launch_o (launch_o)
);

// File: tb/bclk_gen_test.sv
`timescale 1ns/1ps
module bclk_gen_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run = 1'b0;
    logic [7:0] rate = 8'd0;
    logic       cpol = 1'b0;
    logic       cpha = 1'b0;
    logic       sclk, edg, smp, lch;

    int compared = 0;
    int mismatched = 0;
    int edge_cnt = 0;
    bit done = 1'b0;

    int m_acc = 0;
    bit m_sclk = 0, m_edge = 0, m_smp = 0, m_lch = 0;

    always #5 clk = ~clk;

    bclk_gen uut (
        .clk_i(clk), .rst_ni(rst_n), .run_i(run), .rate_i(rate),
        .cpol_i(cpol), .cpha_i(cpha),
        .sclk_o(sclk), .edge_o(edg), .sample_o(smp), .launch_o(lch)
    );

    task automatic model_tick();
        int inc;
        bit lead;
        m_edge = 0; m_smp = 0; m_lch = 0;
        if (!rst_n) begin
            m_acc = 0; m_sclk = 0;
        end else if (!run) begin
            m_acc = 0; m_sclk = cpol;
        end else begin
            inc = (rate == 8'd255) ? 256 : int'(rate);
            m_acc += inc;
            if (m_acc >= 256) begin
                m_acc -= 256;
                m_sclk = !m_sclk;
                m_edge = 1;
                lead = (m_sclk != cpol);
                m_smp = cpha ? !lead : lead;
                m_lch = !m_smp;
            end
        end
    endtask

    task automatic check(input string tag, input bit ok, input string what, input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic step(input string tag);
        @(posedge clk);
        model_tick();
        #1;
        if (edg) edge_cnt++;
        check(tag, {sclk, edg, smp, lch} == {m_sclk, m_edge, m_smp, m_lch},
              "sclk/edge/sample/launch", int'({sclk, edg, smp, lch}),
              int'({m_sclk, m_edge, m_smp, m_lch}));
    endtask

    task automatic steps(input int n, input string tag);
        for (int i = 0; i < n; i++) step(tag);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        steps(4, "R1");
        rst_n = 1'b1;
        step("R1");
        // R2: idle at cpol=1
        cpol = 1'b1; rate = 8'd128;
        steps(5, "R2");
        // R3: fastest power-of-two below all-ones, cpol 0 cpha 0
        cpol = 1'b0; run = 1'b1;
        steps(40, "R3");
        // R2: drop run mid-stream, idle at 0
        run = 1'b0;
        steps(4, "R2");
        // R3: rate 16, explicit edge count over 512 cycles
        rate = 8'd16; run = 1'b1; edge_cnt = 0;
        steps(512, "R3");
        check("R3", edge_cnt == 32, "edges rate16/512cyc", edge_cnt, 32);
        run = 1'b0; steps(2, "R2");
        // R3: slowest rate, first toggle after 256 cycles
        rate = 8'd1; run = 1'b1; edge_cnt = 0;
        steps(255, "R3");
        check("R3", edge_cnt == 0, "no edge before 256 cycles", edge_cnt, 0);
        steps(1, "R3");
        check("R3", edge_cnt == 1 && sclk == 1'b1, "first slow edge", edge_cnt, 1);
        steps(300, "R3");
        run = 1'b0; steps(2, "R2");
        // R4: all-ones acts as 256, cpol 1 cpha 1
        cpol = 1'b1; cpha = 1'b1; rate = 8'd255;
        steps(2, "R2");
        run = 1'b1;
        steps(20, "R4");
        // R5: zero rate, sclk held
        rate = 8'd0;
        steps(30, "R5");
        // R7: cpol 0 cpha 1
        run = 1'b0; cpol = 1'b0; rate = 8'd64;
        steps(2, "R2");
        run = 1'b1;
        steps(40, "R7");
        // R7: cpol 1 cpha 0
        run = 1'b0; cpol = 1'b1; cpha = 1'b0;
        steps(2, "R2");
        run = 1'b1;
        steps(40, "R7");
        // R6: rate 32
        rate = 8'd32;
        steps(50, "R6");
        // R8: non-power-of-two rate, exact count in first 256 cycles
        run = 1'b0; steps(2, "R2");
        rate = 8'd3; run = 1'b1; edge_cnt = 0;
        steps(256, "R8");
        check("R8", edge_cnt == 3, "edges rate3/256cyc", edge_cnt, 3);
        run = 1'b0; steps(2, "R2");
        rate = 8'd200; run = 1'b1; edge_cnt = 0;
        steps(256, "R8");
        check("R8", edge_cnt == 200, "edges rate200/256cyc", edge_cnt, 200);
        // R1: reset while running
        rst_n = 1'b0;
        steps(3, "R1");
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule